// File: doc/BRIEF.md
# CRC-32 Step Unit

This unit advances a running CRC-32 by one operand in a single instruction-style step. The caller supplies the previous checksum as one operand and new data as another. The unit returns the updated checksum one clock later. Three variants share the same checksum operand:

- a single byte taken from the low eight data bits;
- a full word fed most-significant byte first;
- a full word fed least-significant byte first.

The arithmetic is the reflected CRC-32 with polynomial 0xEDB88320. The checksum operand is complemented on entry and the result is complemented on exit. Software can therefore start from zero and pass each result straight into the next step.

Each variant is gated by an instruction-set level input. A variant that the current level does not offer returns an illegal-operation flag. In that case the checksum operand passes through unchanged, so the destination keeps a defined value.

Top module: `crc32_step_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `illegal_op` and `crc_out` are all zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The result and flag for that request appear in the same cycle as `out_valid`.
- R3: Variant code 2'b01 (byte) folds only `data_in[7:0]`, as one byte. `data_in[31:8]` has no effect on `crc_out`.
- R4: Variant code 2'b00 (word, high byte first) folds the four bytes in the order `data_in[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`.
- R5: Variant code 2'b10 (word, low byte first) folds the four bytes in the order `data_in[7:0]`, `[15:8]`, `[23:16]`, `[31:24]`.
- R6: The arithmetic is the reflected CRC-32, polynomial 0xEDB88320. The checksum operand is complemented before folding and the result is complemented after it. Folding the ASCII bytes "123456789" one at a time, starting from an operand of 0 and chaining each result, gives 0xCBF43926.
- R7: The `isa_level` input has these encodings:
  - 0: below version 1.6.1;
  - 1: version 1.6.1;
  - 2 or 3: version 1.6.2 or later.

  Variant 2'b00 needs level 1 or higher. Variants 2'b01 and 2'b10 need level 2 or higher. A request below its required level sets `illegal_op` together with `out_valid`, and `crc_out` then equals `crc_prev`.
- R8: Variant code 2'b11 is reserved. At every level it sets `illegal_op`, and `crc_out` equals `crc_prev`.
- R9: In a cycle where `out_valid` is low, `illegal_op` is low and `crc_out` keeps its previous value, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| variant | input | 2 | 00 word high-first, 01 byte, 10 word low-first, 11 reserved |
| isa_level | input | 2 | 0 pre-1.6.1, 1 = 1.6.1, 2/3 = 1.6.2+ |
| data_in | input | 32 | Data operand |
| crc_prev | input | 32 | Running checksum operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| crc_out | output | 32 | Updated checksum |
| illegal_op | output | 1 | Variant not offered at this level |

## Verification
The bench chains the nine-digit check string through the byte variant. A wrong polynomial, a wrong bit order or missing inversions would all miss 0xCBF43926.

It folds the same word through both word variants and compares the results against byte-by-byte chains in each order. Swapped lane order would make the two word results trade places.

It drives the byte variant with junk in the upper data bits. A unit that folded all four lanes would change its answer.

A sweep over every variant and level checks the gating table and the pass-through of the checksum operand. Idle cycles with moving inputs catch an output register that loads without a request.

// File: rtl/crc32_step_pkg.sv
package crc32_step_pkg;

  typedef enum logic [1:0] {
    VAR_WORD_HI = 2'b00,
    VAR_BYTE    = 2'b01,
    VAR_WORD_LO = 2'b10,
    VAR_RSVD    = 2'b11
  } crc_variant_e;

  localparam logic [1:0] LVL_BASE = 2'd0;
  localparam logic [1:0] LVL_161  = 2'd1;
  localparam logic [1:0] LVL_162  = 2'd2;

  // One byte folded into a reflected CRC: the byte is xored into the low
  // bits, then eight shift steps with conditional polynomial xor.
  function automatic logic [31:0] fold_byte(input logic [31:0] c,
                                            input logic [7:0]  b,
                                            input logic [31:0] poly);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [1:0] min_level(input crc_variant_e v);
    case (v)
      VAR_WORD_HI: return LVL_161;
      VAR_BYTE:    return LVL_162;
      VAR_WORD_LO: return LVL_162;
      default:     return LVL_BASE;
    endcase
  endfunction

endpackage

// File: rtl/crc32_version_gate.sv
module crc32_version_gate
  import crc32_step_pkg::*;
(
  input  logic [1:0] variant,
  input  logic [1:0] isa_level,
  output logic       illegal
);
  crc_variant_e v;
  logic         rsvd;
  logic         too_old;

  always_comb begin
    v       = crc_variant_e'(variant);
    rsvd    = (v == VAR_RSVD);
    too_old = (isa_level < min_level(v));
    illegal = rsvd | too_old;
  end
endmodule

// File: rtl/crc32_byte_order.sv
module crc32_byte_order
  import crc32_step_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8
)(
  input  logic [1:0]          variant,
  input  logic [DATA_W-1:0]   data,
  output logic [BYTES*8-1:0]  lane_bytes,
  output logic [BYTES-1:0]    lane_en
);
  crc_variant_e v;
  assign v = crc_variant_e'(variant);

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    localparam int HI_SRC = DATA_W - 8 - 8 * i;
    localparam int LO_SRC = 8 * i;
    always_comb begin
      case (v)
        VAR_WORD_HI: begin
          lane_bytes[8*i +: 8] = data[HI_SRC +: 8];
          lane_en[i]           = 1'b1;
        end
        VAR_WORD_LO: begin
          lane_bytes[8*i +: 8] = data[LO_SRC +: 8];
          lane_en[i]           = 1'b1;
        end
        VAR_BYTE: begin
          lane_bytes[8*i +: 8] = (i == 0) ? data[7:0] : 8'd0;
          lane_en[i]           = (i == 0);
        end
        default: begin
          lane_bytes[8*i +: 8] = 8'd0;
          lane_en[i]           = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/crc32_fold_lane.sv
module crc32_fold_lane
  import crc32_step_pkg::*;
#(
  parameter logic [31:0] POLY = 32'hEDB88320
)(
  input  logic        en,
  input  logic [31:0] crc_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);
  logic [31:0] folded;
  always_comb begin
    folded = fold_byte(crc_i, byte_i, POLY);
    crc_o  = en ? folded : crc_i;
  end
endmodule

// File: rtl/crc32_step_unit.sv
module crc32_step_unit
  import crc32_step_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter logic [31:0] POLY   = 32'hEDB88320,
  localparam int         BYTES  = DATA_W / 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        variant,
  input  logic [1:0]        isa_level,
  input  logic [DATA_W-1:0] data_in,
  input  logic [31:0]       crc_prev,
  output logic              out_valid,
  output logic [31:0]       crc_out,
  output logic              illegal_op
);
  logic               gate_illegal;
  logic [BYTES*8-1:0] lane_bytes;
  logic [BYTES-1:0]   lane_en;
  logic [31:0]        chain [BYTES+1];
  logic [31:0]        folded_result;
  logic [31:0]        next_crc;

  crc32_version_gate u_gate (
    .variant   (variant),
    .isa_level (isa_level),
    .illegal   (gate_illegal)
  );

  crc32_byte_order #(.DATA_W(DATA_W)) u_order (
    .variant    (variant),
    .data       (data_in),
    .lane_bytes (lane_bytes),
    .lane_en    (lane_en)
  );

  assign chain[0] = ~crc_prev;

  for (genvar i = 0; i < BYTES; i++) begin : g_fold
    crc32_fold_lane #(.POLY(POLY)) u_lane (
      .en     (lane_en[i]),
      .crc_i  (chain[i]),
      .byte_i (lane_bytes[8*i +: 8]),
      .crc_o  (chain[i+1])
    );
  end

  assign folded_result = ~chain[BYTES];
  assign next_crc      = gate_illegal ? crc_prev : folded_result;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      illegal_op <= 1'b0;
      crc_out    <= '0;
    end else begin
      out_valid  <= in_valid;
      illegal_op <= in_valid & gate_illegal;
      if (in_valid) crc_out <= next_crc;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_ILLEGAL_KEEPS_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!illegal_op || crc_out == $past(crc_prev))); // R7
  AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && variant == 2'b11) |=> illegal_op); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(crc_out) && !illegal_op)); // R9
  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !gate_illegal) |->
      ($countones(lane_en) == ((variant == 2'b01) ? 1 : BYTES))); // R3
endmodule

// File: tb/tb_crc32_step_unit.sv
module tb_crc32_step_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  variant;
  logic [1:0]  isa_level;
  logic [31:0] data_in;
  logic [31:0] crc_prev;
  logic        out_valid;
  logic [31:0] crc_out;
  logic        illegal_op;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  crc32_step_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .variant(variant),
    .isa_level(isa_level), .data_in(data_in), .crc_prev(crc_prev),
    .out_valid(out_valid), .crc_out(crc_out), .illegal_op(illegal_op)
  );

  // Bit-serial model: one data bit at a time, LSB first.
  function automatic logic [31:0] m_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb = r[0] ^ b[k];
      r = {1'b0, r[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
    end
    return r;
  endfunction

  function automatic logic [31:0] m_step(input logic [1:0] v, input logic [31:0] d,
                                         input logic [31:0] p);
    logic [31:0] c = ~p;
    if (v == 2'b01) c = m_byte(c, d[7:0]);
    else if (v == 2'b00) for (int k = 3; k >= 0; k--) c = m_byte(c, d[8*k +: 8]);
    else for (int k = 0; k < 4; k++) c = m_byte(c, d[8*k +: 8]);
    return ~c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] v, input logic [1:0] lvl,
                      input logic [31:0] d, input logic [31:0] p,
                      output logic [31:0] res, output logic ill, output logic ov);
    @(negedge clk);
    in_valid = 1; variant = v; isa_level = lvl; data_in = d; crc_prev = p;
    @(negedge clk);
    in_valid = 0;
    res = crc_out; ill = illegal_op; ov = out_valid;
  endtask

  task automatic t_reset;
    rst_n = 0; in_valid = 0; variant = 0; isa_level = 0; data_in = 0; crc_prev = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid", {31'd0, out_valid}, 0);
    chk("R1 illegal", {31'd0, illegal_op}, 0);
    chk("R1 crc", crc_out, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 post valid", {31'd0, out_valid}, 0);
    chk("R1 post crc", crc_out, 0);
  endtask

  task automatic t_check_string;
    logic [31:0] c = 0, r; logic i, o;
    for (int k = 0; k < 9; k++) begin
      step(2'b01, 2'd2, {24'hA5A5A5, 8'h31 + 8'(k)}, c, r, i, o);
      chk("R6 chain step", r, m_step(2'b01, {24'd0, 8'h31 + 8'(k)}, c));
      c = r;
    end
    chk("R6 check value", c, 32'hCBF43926);
  endtask

  task automatic t_byte_upper;
    logic [31:0] r1, r2; logic i, o;
    step(2'b01, 2'd2, 32'h0000005A, 32'h12345678, r1, i, o);
    step(2'b01, 2'd3, 32'hFFFFFF5A, 32'h12345678, r2, i, o);
    chk("R3 byte value", r1, m_step(2'b01, 32'h5A, 32'h12345678));
    chk("R3 upper ignored", r2, r1);
  endtask

  task automatic t_words;
    logic [31:0] r, c; logic i, o;
    step(2'b00, 2'd1, 32'h31323334, 32'h0, r, i, o);
    c = 0;
    for (int k = 0; k < 4; k++) c = ~m_byte(~c, 8'h31 + 8'(k));
    chk("R4 high-first equals byte chain 1234", r, c);
    chk("R2 out_valid with result", {31'd0, o}, 1);
    step(2'b10, 2'd2, 32'h34333231, 32'h0, r, i, o);
    chk("R5 low-first equals byte chain 1234", r, c);
    step(2'b00, 2'd2, 32'hDEADBEEF, 32'hCAFEF00D, r, i, o);
    chk("R4 random word", r, m_step(2'b00, 32'hDEADBEEF, 32'hCAFEF00D));
    step(2'b10, 2'd2, 32'hDEADBEEF, 32'hCAFEF00D, r, i, o);
    chk("R5 random word", r, m_step(2'b10, 32'hDEADBEEF, 32'hCAFEF00D));
    @(negedge clk);
    chk("R2 valid drops", {31'd0, out_valid}, 0);
  endtask

  task automatic t_gating;
    logic [31:0] r, p; logic i, o, exp_ill;
    for (int lv = 0; lv < 4; lv++) begin
      for (int v = 0; v < 4; v++) begin
        p = 32'h1000_0000 + 32'(lv * 16 + v);
        exp_ill = (v == 3) || (v == 0 && lv < 1) || ((v == 1 || v == 2) && lv < 2);
        step(2'(v), 2'(lv), 32'h89ABCDEF, p, r, i, o);
        if (v == 3) chk("R8 reserved flag", {31'd0, i}, 1);
        else chk("R7 gate flag", {31'd0, i}, {31'd0, exp_ill});
        chk(v == 3 ? "R8 crc" : "R7 crc", r,
            exp_ill ? p : m_step(2'(v), 32'h89ABCDEF, p));
      end
    end
  endtask

  task automatic t_idle;
    logic [31:0] r, held; logic i, o;
    step(2'b11, 2'd2, 32'h1, 32'h55AA55AA, r, i, o);
    held = r;
    @(negedge clk);
    data_in = 32'hFFFF0000; crc_prev = 32'h0BADF00D; variant = 2'b00;
    @(negedge clk);
    chk("R9 crc held", crc_out, held);
    chk("R9 illegal low", {31'd0, illegal_op}, 0);
    chk("R9 valid low", {31'd0, out_valid}, 0);
  endtask

  initial begin
    t_reset();
    t_check_string();
    t_byte_upper();
    t_words();
    t_gating();
    t_idle();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule